// File: doc/BRIEF.md
# Alternating Sequence Flag Tagger and Checker

This block guards a one-way stream of 32-bit messages with a single alternating flag. The transmit half takes a 31-bit payload, puts its current flag in the top bit of the outgoing word, and inverts the flag after every message. The receive half looks at the top bit of each arriving word and compares it with the flag it last accepted. An equal flag means that a message was repeated or that one went missing. The word is still passed on, and an error strobe is raised alongside it. Each half runs on its own valid strobe and has a one-cycle registered path.

The transmit half has two states. `SEQ_LO` and `SEQ_HI` give the flag that the next message will carry. Every accepted payload moves the transmitter from one state to the other, and idle cycles hold the state.

The receive history has three states, held as a 2-bit register made of a valid flag and a value. `HIST_NONE` (code 2'b00) is the state after reset or after `rx_init_i`. `HIST_ZERO` (2'b10) means the last accepted flag was 0, and `HIST_ONE` (2'b11) means it was 1. Its transitions are:
- *accept*: from any state, on a message whose flag differs from the history, or from `HIST_NONE` on any message. The history moves to the state of the arriving flag.
- *reject*: on a flag equal to the history. The state is held.
- *clear*: `rx_init_i` alone moves the history to `HIST_NONE`.

Top module: `seqtag_link`

## Requirements
- R1: After reset `tx_valid_o`, `rx_valid_o` and `rx_seq_err_o` are 0.
- R2: One cycle after `tx_valid_i`, `tx_valid_o` is 1 and `tx_msg_o[30:0]` equals the payload that was presented. With no input valid, `tx_valid_o` is 0 in the next cycle.
- R3: `tx_msg_o[31]` is 0 on the first message after reset and inverts on each later message. Idle cycles do not change it.
- R4: One cycle after `rx_valid_i`, `rx_valid_o` is 1 and `rx_msg_o` equals the input word in all 32 bits. This holds for flagged words too.
- R5: The first message after reset or after `rx_init_i` raises no error, whatever its bit 31.
- R6: `rx_seq_err_o` is 1, for that output cycle only, exactly when the word's bit 31 equals the last accepted flag. It is never 1 without `rx_valid_o`.
- R7: An accepted message stores its flag as the new history. A rejected message leaves the history unchanged, so a run of equal flags is flagged on every repeat.
- R8: `rx_init_i` clears the history. When it arrives in the same cycle as a message, that message is judged as the first one after initialisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid_i | input | 1 | Payload strobe for the transmit half |
| tx_payload_i | input | 31 | Payload to be tagged |
| tx_valid_o | output | 1 | Tagged message strobe |
| tx_msg_o | output | 32 | Tagged message, flag in bit 31 |
| rx_init_i | input | 1 | Clears the receive history |
| rx_valid_i | input | 1 | Incoming message strobe |
| rx_msg_i | input | 32 | Incoming message, flag in bit 31 |
| rx_valid_o | output | 1 | Delivered message strobe |
| rx_msg_o | output | 32 | Delivered message, unchanged |
| rx_seq_err_o | output | 1 | Illegal-sequence strobe, aligned with `rx_valid_o` |

## Verification
The assertions assume that the input valids and `rx_init_i` are 0 or 1 and are stable around the clock edge. They place no limit on how messages may be spaced or on which flags they carry. The stimulus drives inputs on the falling edge and holds each strobe for a single cycle. The receive side sees every 4-message flag pattern after an initialisation, back-to-back and with gaps, plus initialisation alone and initialisation together with a message. The transmit side is driven with payloads spread over the full 31-bit range and with idle gaps of different lengths.

// File: rtl/seqtag_pkg.sv
package seqtag_pkg;

    // Transmit flag state
    typedef enum logic {
        SEQ_LO = 1'b0,
        SEQ_HI = 1'b1
    } seq_e;

    // Receive history: bit 1 = known, bit 0 = last accepted flag
    typedef enum logic [1:0] {
        HIST_NONE = 2'b00,
        HIST_ZERO = 2'b10,
        HIST_ONE  = 2'b11
    } hist_e;

    function automatic hist_e hist_of(input logic flag);
        return flag ? HIST_ONE : HIST_ZERO;
    endfunction

endpackage

// File: rtl/seqtag_tx.sv
module seqtag_tx
    import seqtag_pkg::*;
#(
    parameter int MSG_W = 32,
    localparam int PAY_W = MSG_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PAY_W-1:0] in_payload,
    output logic             out_valid,
    output logic [MSG_W-1:0] out_msg
);

    seq_e seq_q, seq_d;

    // next-state process
    always_comb begin
        seq_d = seq_q;
        if (in_valid) begin
            unique case (seq_q)
                SEQ_LO:  seq_d = SEQ_HI;
                SEQ_HI:  seq_d = SEQ_LO;
                default: seq_d = SEQ_LO;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_LO;
        else        seq_q <= seq_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_msg   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_msg <= {seq_q == SEQ_HI, in_payload};
        end
    end

    AST_TX_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_msg[PAY_W-1:0] == $past(in_payload))); // R2
    AST_TX_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(seq_q)); // R3
    AST_TX_FLAG_USED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_msg[MSG_W-1] != (seq_q == SEQ_HI))); // R3

endmodule

// File: rtl/seqtag_rx.sv
module seqtag_rx
    import seqtag_pkg::*;
#(
    parameter int MSG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             in_valid,
    input  logic [MSG_W-1:0] in_msg,
    output logic             out_valid,
    output logic [MSG_W-1:0] out_msg,
    output logic             seq_err
);

    hist_e hist_q, hist_d, hist_eff;
    logic  flag, dup;

    assign flag = in_msg[MSG_W-1];

    // next-state process
    always_comb begin
        hist_eff = init ? HIST_NONE : hist_q;
        dup      = 1'b0;
        hist_d   = hist_eff;
        if (in_valid) begin
            unique case (hist_eff)
                HIST_NONE: hist_d = hist_of(flag);
                HIST_ZERO: begin
                    dup    = !flag;
                    hist_d = flag ? HIST_ONE : HIST_ZERO;
                end
                HIST_ONE: begin
                    dup    = flag;
                    hist_d = flag ? HIST_ONE : HIST_ZERO;
                end
                default: hist_d = HIST_NONE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= HIST_NONE;
        else        hist_q <= hist_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_msg   <= '0;
            seq_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            seq_err   <= dup;
            if (in_valid) out_msg <= in_msg;
        end
    end

    AST_RX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_msg == $past(in_msg))); // R4
    AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> out_valid); // R6
    AST_FIRST_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (init || hist_q == HIST_NONE)) |=> !seq_err); // R5
    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !init && hist_q != HIST_NONE && hist_q == hist_of(flag)) |=> (seq_err && $stable(hist_q))); // R7
    AST_HIST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        hist_q == HIST_NONE || hist_q == HIST_ZERO || hist_q == HIST_ONE); // R7

endmodule

// File: rtl/seqtag_link.sv
module seqtag_link #(
    parameter int MSG_W = 32,
    localparam int PAY_W = MSG_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_valid_i,
    input  logic [PAY_W-1:0] tx_payload_i,
    output logic             tx_valid_o,
    output logic [MSG_W-1:0] tx_msg_o,
    input  logic             rx_init_i,
    input  logic             rx_valid_i,
    input  logic [MSG_W-1:0] rx_msg_i,
    output logic             rx_valid_o,
    output logic [MSG_W-1:0] rx_msg_o,
    output logic             rx_seq_err_o
);

    seqtag_tx #(.MSG_W(MSG_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (tx_valid_i),
        .in_payload (tx_payload_i),
        .out_valid  (tx_valid_o),
        .out_msg    (tx_msg_o)
    );

    seqtag_rx #(.MSG_W(MSG_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (rx_init_i),
        .in_valid  (rx_valid_i),
        .in_msg    (rx_msg_i),
        .out_valid (rx_valid_o),
        .out_msg   (rx_msg_o),
        .seq_err   (rx_seq_err_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $rose(rst_n) |-> (!tx_valid_o && !rx_valid_o && !rx_seq_err_o)); // R1

endmodule

// File: tb/seqtag_link_tb.sv
module seqtag_link_tb;

    localparam int MSG_W = 32;
    localparam int PAY_W = MSG_W - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tx_valid_i = 1'b0;
    logic [PAY_W-1:0] tx_payload_i = '0;
    logic             tx_valid_o;
    logic [MSG_W-1:0] tx_msg_o;
    logic             rx_init_i = 1'b0;
    logic             rx_valid_i = 1'b0;
    logic [MSG_W-1:0] rx_msg_i = '0;
    logic             rx_valid_o;
    logic [MSG_W-1:0] rx_msg_o;
    logic             rx_seq_err_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    int tx_seq = 0;   // model of transmit flag
    int rx_hist = -1; // -1 none, else last accepted flag

    always #4 clk = ~clk;

    seqtag_link #(.MSG_W(MSG_W)) u_dut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tx_send(input logic [PAY_W-1:0] pay, input int gap);
        @(negedge clk);
        tx_valid_i   = 1'b1;
        tx_payload_i = pay;
        @(posedge clk); #2;
        tx_valid_i = 1'b0;
        check("R2 valid", 64'(tx_valid_o), 64'd1);
        check("R2 payload", 64'(tx_msg_o[PAY_W-1:0]), 64'(pay));
        check("R3 flag", 64'(tx_msg_o[MSG_W-1]), 64'(tx_seq));
        tx_seq = 1 - tx_seq;
        for (int g = 0; g < gap; g++) begin
            @(posedge clk); #2;
            check("R2 idle", 64'(tx_valid_o), 64'd0);
        end
    endtask

    task automatic rx_send(input bit init, input bit flag, input logic [PAY_W-1:0] pay, input int gap);
        logic [MSG_W-1:0] w;
        bit exp_err;
        w = {flag, pay};
        if (init) rx_hist = -1;
        exp_err = (rx_hist != -1) && (rx_hist == int'(flag));
        if (!exp_err) rx_hist = int'(flag);
        @(negedge clk);
        rx_init_i  = init;
        rx_valid_i = 1'b1;
        rx_msg_i   = w;
        @(posedge clk); #2;
        rx_init_i  = 1'b0;
        rx_valid_i = 1'b0;
        check("R4 valid", 64'(rx_valid_o), 64'd1);
        check("R4 data", 64'(rx_msg_o), 64'(w));
        check("R6 err", 64'(rx_seq_err_o), 64'(exp_err));
        for (int g = 0; g < gap; g++) begin
            @(posedge clk); #2;
            check("R6 single cycle", 64'({rx_valid_o, rx_seq_err_o}), 64'd0);
        end
    endtask

    task automatic rx_init_only();
        @(negedge clk);
        rx_init_i = 1'b1;
        @(posedge clk); #2;
        rx_init_i = 1'b0;
        check("R8 init no output", 64'({rx_valid_o, rx_seq_err_o}), 64'd0);
        rx_hist = -1;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #2;
        check("R1 tx valid", 64'(tx_valid_o), 64'd0);
        check("R1 rx valid", 64'(rx_valid_o), 64'd0);
        check("R1 rx err", 64'(rx_seq_err_o), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1 after release", 64'({tx_valid_o, rx_valid_o, rx_seq_err_o}), 64'd0);

        // transmit: payload sweep with varied gaps (R2, R3)
        for (int i = 0; i < 40; i++)
            tx_send(PAY_W'(32'(i) * 32'h0913_5A27 ^ 32'h2AC3_1F0E), i % 3);
        tx_send('1, 0);
        tx_send('0, 2);

        // receive: first message after reset with flag 1 (R5)
        rx_send(1'b0, 1'b1, 31'h0000_0123, 0);
        rx_send(1'b0, 1'b1, 31'h0000_0456, 1); // repeat flagged, R7 hist held
        rx_send(1'b0, 1'b1, 31'h0000_0789, 0); // flagged again
        rx_send(1'b0, 1'b0, 31'h7FFF_FFFF, 0);

        // every 4-flag pattern after init, with and without gaps (R5, R6, R7, R8)
        for (int p = 0; p < 16; p++) begin
            rx_init_only();
            for (int k = 0; k < 4; k++)
                rx_send(1'b0, p[k], PAY_W'(32'(p * 4 + k) * 32'h0001_3579), (p + k) % 2);
        end

        // init in the same cycle as a message whose flag repeats the history (R8)
        rx_send(1'b0, 1'b0, 31'h11, 0);
        rx_send(1'b1, 1'b0, 31'h22, 0);
        rx_send(1'b0, 1'b0, 31'h33, 0);
        rx_send(1'b1, 1'b1, 31'h44, 1);
        rx_send(1'b0, 1'b0, 31'h55, 1);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule